// File: doc/BRIEF.md
# CAN Error Status and Interrupt Register

This block is the software view of a CAN controller's fault-confinement state. Every cycle it samples the receive and transmit error counters and the bus-off, error-passive and warning flags from the confinement unit. It also keeps a 3-bit last-error code that the protocol engine updates. All of this is packed into one 32-bit read-only-looking status word. The only field software can change in that word is the code.

A second word holds an error-interrupt enable and a pending bit. While the enable is set, the pending bit is raised when any sampled flag changes or when the engine reports a new error. Software clears it by writing one.

Hardware never produces code 7. Software can write 7 into the code field and later see whether hardware has overwritten it.

Top module: `can_errstat_reg`

## Requirements
- R1: After reset, the status word (offset 0x0), the control word (offset 0x4) and `irq_o` are all zero.
- R2: The status word holds the following fields, and all other bits read zero:
  - receive counter in bits 31:24;
  - transmit counter in bits 23:16;
  - error code in bits 6:4;
  - bus-off in bit 2;
  - passive in bit 1;
  - warning in bit 0.

  Counter and flag inputs appear in the word one clock after they are applied.
- R3: An error strobe whose code is 1 to 6 loads that code into the error-code field. The codes are 1 stuff, 2 form, 3 acknowledge, 4 recessive bit, 5 dominant bit, 6 CRC. A strobe carrying code 0 or 7 leaves the field unchanged.
- R4: A success strobe sets the error-code field to 0. If an error strobe with a valid code arrives in the same cycle, the error code is stored instead.
- R5: A write to offset 0x0 loads `wdata[6:4]` into the error-code field, and any value including 7 is accepted. A valid hardware error strobe or a success strobe in the same cycle takes priority over the write.
- R6: Writes to offset 0x0 leave the counter and flag fields unchanged; they keep showing the sampled inputs.
- R7: The control word has the enable in bit 0 (read/write) and pending in bit 8 (read, write-one-to-clear). All its other bits read zero.
- R8: Pending sets when the enable is 1 and either a valid error strobe occurs or the sampled bus-off/passive/warning inputs differ from the stored flags. It never sets while the enable is 0. `irq_o` equals pending AND enable.
- R9: Writing 1 to control bit 8 clears pending, and writing 0 there leaves it unchanged. A setting event in the same cycle as the clear wins, so pending stays 1.
- R10: A success strobe alone does not set pending.
- R11: Reads at any offset other than 0x0 and 0x4 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_cnt_i | input | 8 | Receive error counter from confinement unit |
| tx_cnt_i | input | 8 | Transmit error counter from confinement unit |
| bus_off_i | input | 1 | Bus-off flag |
| passive_i | input | 1 | Error-passive flag |
| warn_i | input | 1 | Warning-level flag |
| err_stb_i | input | 1 | Error detected strobe from protocol engine |
| err_code_i | input | 3 | Error type accompanying the strobe |
| ok_stb_i | input | 1 | Frame sent or received correctly |
| reg_addr_i | input | ADDR_W (4) | Byte offset of register access |
| reg_wr_i | input | 1 | Write enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational from offset) |
| irq_o | output | 1 | Error interrupt request |

## Verification
The bench builds the block with its default 4-bit offset width. This width puts both mapped words and the unmapped offset 0x8 within reach of the register port.

Counter inputs are driven with asymmetric patterns so that a swap of the two counter fields or a shifted flag shows up. Every error code, including the ignored 0 and 7, is strobed. The collision cases are all driven deliberately:
- error and success strobes in the same cycle;
- a hardware event during a software write;
- a setting event during a clear.

// File: rtl/can_es_pkg.sv
package can_es_pkg;
  localparam int DATA_W     = 32;
  localparam int CNT_W      = 8;
  localparam int CODE_W     = 3;
  localparam int FLAG_W     = 3;
  localparam int RXC_LSB    = 24;
  localparam int TXC_LSB    = 16;
  localparam int CODE_LSB   = 4;
  localparam int IE_BIT     = 0;
  localparam int PEND_BIT   = 8;
  localparam int STATUS_OFS = 0;
  localparam int CTRL_OFS   = 4;

  typedef enum logic [CODE_W-1:0] {
    EC_NONE  = 3'd0,
    EC_STUFF = 3'd1,
    EC_FORM  = 3'd2,
    EC_ACK   = 3'd3,
    EC_REC   = 3'd4,
    EC_DOM   = 3'd5,
    EC_CRC   = 3'd6,
    EC_SOFT  = 3'd7
  } err_code_e;

  function automatic logic hw_code_ok(input logic [CODE_W-1:0] c);
    return (c != EC_NONE) && (c != EC_SOFT);
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(
      input logic [CNT_W-1:0]  rxc,
      input logic [CNT_W-1:0]  txc,
      input logic [CODE_W-1:0] code,
      input logic [FLAG_W-1:0] flg);
    logic [DATA_W-1:0] w;
    w = '0;
    w[RXC_LSB +: CNT_W]   = rxc;
    w[TXC_LSB +: CNT_W]   = txc;
    w[CODE_LSB +: CODE_W] = code;
    w[FLAG_W-1:0]         = flg;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic ie, input logic pend);
    logic [DATA_W-1:0] w;
    w = '0;
    w[IE_BIT]   = ie;
    w[PEND_BIT] = pend;
    return w;
  endfunction
endpackage

// File: rtl/es_snapshot.sv
module es_snapshot
  import can_es_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [CNT_W-1:0]  rx_cnt_q,
  output logic [CNT_W-1:0]  tx_cnt_q,
  output logic [FLAG_W-1:0] flags_q,
  output logic              flag_chg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt_q <= '0;
      tx_cnt_q <= '0;
      flags_q  <= '0;
    end else begin
      rx_cnt_q <= rx_cnt_i;
      tx_cnt_q <= tx_cnt_i;
      flags_q  <= flags_i;
    end
  end

  assign flag_chg = (flags_i != flags_q);

  assert_follow_inputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_cnt_q == $past(rx_cnt_i)) && (tx_cnt_q == $past(tx_cnt_i))
             && (flags_q == $past(flags_i)));
endmodule

// File: rtl/es_lec.sv
module es_lec
  import can_es_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_stb_i,
  input  logic [CODE_W-1:0] err_code_i,
  input  logic              ok_stb_i,
  input  logic              sw_we_i,
  input  logic [CODE_W-1:0] sw_code_i,
  output logic [CODE_W-1:0] code_q,
  output logic              hw_err_ev
);
  assign hw_err_ev = err_stb_i && hw_code_ok(err_code_i);

  always_ff @(posedge clk) begin
    if (!rst_n)          code_q <= EC_NONE;
    else if (hw_err_ev)  code_q <= err_code_i;
    else if (ok_stb_i)   code_q <= EC_NONE;
    else if (sw_we_i)    code_q <= sw_code_i;
  end

  assert_load_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err_ev |=> code_q == $past(err_code_i));
  assert_ok_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_stb_i && !hw_err_ev) |=> code_q == EC_NONE);
  assert_no_hw_seven_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we_i |=> (code_q != EC_SOFT) || ($past(code_q) == EC_SOFT));
  assert_bad_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_err_ev && !ok_stb_i && !sw_we_i) |=> $stable(code_q));
endmodule

// File: rtl/es_irq.sv
module es_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ie_we_i,
  input  logic ie_wdata_i,
  input  logic pend_clr_i,
  input  logic evt_i,
  output logic ie_q,
  output logic pend_q,
  output logic irq_o
);
  logic pend_set;
  assign pend_set = evt_i && ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ie_we_i) ie_q <= ie_wdata_i;
      if (pend_set)        pend_q <= 1'b1;
      else if (pend_clr_i) pend_q <= 1'b0;
    end
  end

  assign irq_o = pend_q && ie_q;

  assert_rise_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(ie_q) && $past(evt_i));
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr_i && !pend_set) |=> !pend_q);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set |=> pend_q);
endmodule

// File: rtl/can_errstat_reg.sv
module can_errstat_reg
  import can_es_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic              bus_off_i,
  input  logic              passive_i,
  input  logic              warn_i,
  input  logic              err_stb_i,
  input  logic [CODE_W-1:0] err_code_i,
  input  logic              ok_stb_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(CTRL_OFS);

  logic [CNT_W-1:0]  rxc_q, txc_q;
  logic [FLAG_W-1:0] flags_q;
  logic [CODE_W-1:0] code_q;
  logic              flag_chg, hw_err_ev, ie_q, pend_q;
  logic              sel_status, sel_ctrl, sw_code_we, ctrl_we;

  assign sel_status = (reg_addr_i == A_STATUS);
  assign sel_ctrl   = (reg_addr_i == A_CTRL);
  assign sw_code_we = reg_wr_i && sel_status;
  assign ctrl_we    = reg_wr_i && sel_ctrl;

  es_snapshot u_snap (
    .clk(clk), .rst_n(rst_n),
    .rx_cnt_i(rx_cnt_i), .tx_cnt_i(tx_cnt_i),
    .flags_i({bus_off_i, passive_i, warn_i}),
    .rx_cnt_q(rxc_q), .tx_cnt_q(txc_q), .flags_q(flags_q),
    .flag_chg(flag_chg)
  );

  es_lec u_lec (
    .clk(clk), .rst_n(rst_n),
    .err_stb_i(err_stb_i), .err_code_i(err_code_i), .ok_stb_i(ok_stb_i),
    .sw_we_i(sw_code_we), .sw_code_i(reg_wdata_i[CODE_LSB +: CODE_W]),
    .code_q(code_q), .hw_err_ev(hw_err_ev)
  );

  es_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .ie_we_i(ctrl_we), .ie_wdata_i(reg_wdata_i[IE_BIT]),
    .pend_clr_i(ctrl_we && reg_wdata_i[PEND_BIT]),
    .evt_i(flag_chg || hw_err_ev),
    .ie_q(ie_q), .pend_q(pend_q), .irq_o(irq_o)
  );

  always_comb begin
    if (sel_status)    reg_rdata_o = pack_status(rxc_q, txc_q, code_q, flags_q);
    else if (sel_ctrl) reg_rdata_o = pack_ctrl(ie_q, pend_q);
    else               reg_rdata_o = '0;
  end

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ie_q);
  assert_ok_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_stb_i && !err_stb_i && !flag_chg && !pend_q) |=> !pend_q);
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_status && !sel_ctrl) |-> reg_rdata_o == '0);
endmodule

// File: tb/can_errstat_reg_test.sv
`timescale 1ns/1ps
module can_errstat_reg_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  rx_cnt = 0, tx_cnt = 0;
  logic        boff = 0, pasv = 0, warn = 0;
  logic        err_stb = 0, ok_stb = 0, wr = 0;
  logic [2:0]  err_code = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  can_errstat_reg #(.ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .rx_cnt_i(rx_cnt), .tx_cnt_i(tx_cnt),
    .bus_off_i(boff), .passive_i(pasv), .warn_i(warn),
    .err_stb_i(err_stb), .err_code_i(err_code), .ok_stb_i(ok_stb),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  function automatic logic [31:0] stat(input logic [7:0] r, input logic [7:0] t,
                                       input logic [2:0] c, input logic b,
                                       input logic p, input logic w);
    return (32'(r) << 24) | (32'(t) << 16) | (32'(c) << 4)
         | (32'(b) << 2) | (32'(p) << 1) | 32'(w);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1; tick(); wr = 0; wdata = 0;
  endtask

  task automatic hw_err(input logic [2:0] c);
    err_stb = 1; err_code = c; tick(); err_stb = 0; err_code = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); check("R1 status", d, 0);
    rd(4'h4, d); check("R1 ctrl", d, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    rx_cnt = 8'hA5; tx_cnt = 8'h3C; boff = 1; pasv = 0; warn = 1;
    rd(4'h0, d); check("R2 not yet sampled", d, 0);
    tick();
    rd(4'h0, d); check("R2 layout", d, stat(8'hA5, 8'h3C, 0, 1, 0, 1));
    rd(4'h4, d); check("R8 no pend when disabled", d, 0);
    rx_cnt = 8'h01; tx_cnt = 8'hFE; boff = 0; pasv = 1; warn = 0; tick();
    rd(4'h0, d); check("R2 layout2", d, stat(8'h01, 8'hFE, 0, 0, 1, 0));
  endtask

  task automatic t_codes();
    logic [31:0] d;
    for (int c = 1; c <= 6; c++) begin
      hw_err(3'(c));
      rd(4'h0, d); check("R3 code", 32'(d[6:4]), c);
    end
    hw_err(3'd7); rd(4'h0, d); check("R3 code7 ignored", 32'(d[6:4]), 6);
    hw_err(3'd0); rd(4'h0, d); check("R3 code0 ignored", 32'(d[6:4]), 6);
  endtask

  task automatic t_success();
    logic [31:0] d;
    ok_stb = 1; tick(); ok_stb = 0;
    rd(4'h0, d); check("R4 ok clears", 32'(d[6:4]), 0);
    ok_stb = 1; err_stb = 1; err_code = 3'd3; tick();
    ok_stb = 0; err_stb = 0; err_code = 0;
    rd(4'h0, d); check("R4 error beats ok", 32'(d[6:4]), 3);
  endtask

  task automatic t_sw();
    logic [31:0] d;
    wr_reg(4'h0, 32'hFFFF_FF70);
    rd(4'h0, d);
    check("R5 sw writes 7", 32'(d[6:4]), 7);
    check("R6 fields kept", d, stat(8'h01, 8'hFE, 7, 0, 1, 0));
    err_stb = 1; err_code = 3'd2; wr_reg(4'h0, 32'h70);
    err_stb = 0; err_code = 0;
    rd(4'h0, d); check("R5 hw beats sw", 32'(d[6:4]), 2);
    ok_stb = 1; wr_reg(4'h0, 32'h50); ok_stb = 0;
    rd(4'h0, d); check("R5 ok beats sw", 32'(d[6:4]), 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr_reg(4'h4, 32'hFFFF_FEFF);
    rd(4'h4, d); check("R7 ctrl bits", d, 32'h1);
    check("R8 idle irq", {31'd0, irq}, 0);
    hw_err(3'd5);
    check("R8 irq on error", {31'd0, irq}, 1);
    rd(4'h4, d); check("R7 pend readable", d, 32'h101);
    wr_reg(4'h4, 32'h1);
    check("R9 write0 keeps", {31'd0, irq}, 1);
    wr_reg(4'h4, 32'h101);
    check("R9 w1c", {31'd0, irq}, 0);
    warn = 1; tick();
    check("R8 irq on flag change", {31'd0, irq}, 1);
    tick(); wr_reg(4'h4, 32'h101);
    check("R9 clr2", {31'd0, irq}, 0);
    ok_stb = 1; tick(); ok_stb = 0;
    check("R10 ok no irq", {31'd0, irq}, 0);
    boff = 1; wr_reg(4'h4, 32'h101);
    check("R9 set beats clr", {31'd0, irq}, 1);
    wr_reg(4'h4, 32'h100);
    rd(4'h4, d); check("R8 disable clears", d, 0);
    hw_err(3'd1); pasv = 0; tick();
    check("R8 no irq disabled", {31'd0, irq}, 0);
    rd(4'h4, d); check("R8 no pend disabled", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(4'h8, d); check("R11 unmapped", d, 0);
    rd(4'hC, d); check("R11 unmapped C", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_layout();
    t_codes();
    t_success();
    t_sw();
    t_irq();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule